// File: doc/BRIEF.md
# Sprite Line Tile Scheduler

Once per scanline this block walks an ordered list of the sprites that touch the line and emits one tile-draw request per clock. Each request names a pattern tile and the screen x position of its 8-pixel row. The block owns a sprite-only line buffer. The buffer is wiped on the line-start strobe. Every 8-pixel write first reads the pixels already at that place: an opaque pixel that is already there wins, and an opaque-on-opaque meeting raises a sticky collision flag.

Drawing is bounded by two limits per line: a sprite count and a sprite-tile budget. Both depend on the screen mode, which is 40 cells wide or 32 cells wide. When a limit stops the walk while list entries, or the tail of a sprite, are still waiting, a sticky overflow flag is raised. A status read clears both flags.

The list is read through an index port. The block drives `spr_idx` and the surrounding logic returns that entry's attributes in the same cycle. Pattern rows come back the same way on `pat_pix` for the tile currently requested. A compositor reads the finished line through `rd_x`/`rd_pix`.

Top module: `sprite_line_sched`

## Requirements
- R1: After reset, `busy`, `overflow` and `collision` are 0 and every line-buffer pixel reads 0.
- R2: A `line_start` pulse clears every line-buffer pixel to 0 before any tile of that line is written.
- R3: A sprite of size code s (width s+1 tiles) issues its tiles on consecutive active `draw_valid` cycles. Column c has x = spr_x + 8c. Its tile index is spr_tile + c, or spr_tile + s − c when `spr_hflip` is 1.
- R4: Pixel i (0 = leftmost) of a tile lands at x + i. Without flip it is taken from `pat_pix` bits [4(7−i)+3 : 4(7−i)]; with flip it is taken from bits [4i+3 : 4i]. Pixels at x ≥ 320 (wide) or x ≥ 256 (narrow) are dropped.
- R5: Sprites are drawn in list order. A pixel already non-zero in the buffer is never overwritten within the line.
- R6: `collision` is set when any pixel written is non-zero where the buffer already holds non-zero. Overlap of a transparent (zero) pixel with anything does not set it. Once set, it stays set until a status read.
- R7: At most 20 sprites (wide) or 16 sprites (narrow) are drawn per line.
- R8: At most 40 tiles (wide) or 32 tiles (narrow) are drawn per line. The budget can end a line part-way through a sprite.
- R9: `overflow` is set only when a limit ends the line while sprites or sprite tiles remain. Exactly filling a limit with the last entry does not set it.
- R10: A `status_rd` pulse clears `overflow` and `collision`, unless the same cycle sets them.
- R11: `busy` rises in the cycle after `line_start` and falls when the line ends. `draw_valid` is only ever high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_start | input | 1 | Start-of-line strobe |
| wide | input | 1 | 1 = 40-cell mode, 0 = 32-cell mode; latched at line start |
| spr_count | input | 6 | Number of entries in the line's sprite list |
| spr_idx | output | 6 | List entry currently addressed |
| spr_x | input | 9 | X position of the addressed sprite |
| spr_size | input | 2 | Width in tiles minus one |
| spr_tile | input | 11 | Base tile index |
| spr_hflip | input | 1 | Horizontal flip |
| draw_valid | output | 1 | A tile row is drawn this cycle |
| draw_tile | output | 11 | Tile index of the request |
| draw_x | output | 9 | X position of the request |
| pat_pix | input | 32 | Eight 4-bit pixels of the requested tile row |
| rd_x | input | 9 | Line-buffer read position |
| rd_pix | output | 4 | Line-buffer pixel at `rd_x` |
| status_rd | input | 1 | Status read; clears both flags |
| busy | output | 1 | Line in progress |
| overflow | output | 1 | Sticky limit-overflow flag |
| collision | output | 1 | Sticky sprite-collision flag |

## Verification
The bench builds the block with its default parameters: 40/32 cells, 20/16 sprites and 4-bit pixels. With those values both the sprite-count and the tile-budget limits are reachable in each mode with lists of 64 entries or fewer. The buffer edges at 320 and 256 pixels sit inside the 9-bit x range. A behavioural line model in the bench predicts the request stream, the whole buffer and both flags. Directed lists push on exact-fill versus overflow, a mid-sprite budget cut, flip, edge clipping, and transparent versus opaque overlap.

// File: rtl/sprite_line_sched.sv
module sprite_line_sched #(
  parameter int PIXW         = 4,
  parameter int TILEW        = 11,
  parameter int XW           = 9,
  parameter int IDXW         = 6,
  parameter int WIDE_CELLS   = 40,
  parameter int NARROW_CELLS = 32,
  parameter int WIDE_SPR     = 20,
  parameter int NARROW_SPR   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              wide,
  input  logic [IDXW-1:0]   spr_count,
  output logic [IDXW-1:0]   spr_idx,
  input  logic [XW-1:0]     spr_x,
  input  logic [1:0]        spr_size,
  input  logic [TILEW-1:0]  spr_tile,
  input  logic              spr_hflip,
  output logic              draw_valid,
  output logic [TILEW-1:0]  draw_tile,
  output logic [XW-1:0]     draw_x,
  input  logic [8*PIXW-1:0] pat_pix,
  input  logic [XW-1:0]     rd_x,
  output logic [PIXW-1:0]   rd_pix,
  input  logic              status_rd,
  output logic              busy,
  output logic              overflow,
  output logic              collision
);
  localparam int BUF_PIX = WIDE_CELLS * 8;
  localparam int BUF_IW  = $clog2(BUF_PIX);
  localparam int CNTW    = $clog2(WIDE_CELLS + 1);
  localparam logic [XW:0]      SCR_W   = (XW+1)'(WIDE_CELLS * 8);
  localparam logic [XW:0]      SCR_N   = (XW+1)'(NARROW_CELLS * 8);
  localparam logic [IDXW-1:0]  LSPR_W  = IDXW'(WIDE_SPR);
  localparam logic [IDXW-1:0]  LSPR_N  = IDXW'(NARROW_SPR);
  localparam logic [CNTW-1:0]  LTIL_W  = CNTW'(WIDE_CELLS);
  localparam logic [CNTW-1:0]  LTIL_N  = CNTW'(NARROW_CELLS);

  logic [PIXW-1:0]   buf_q [BUF_PIX];
  logic              wide_q;
  logic [IDXW-1:0]   cnt_q, idx_q;
  logic [1:0]        col_q;
  logic [CNTW-1:0]   tiles_q;

  logic [XW:0]       scr_w;
  logic              list_end, at_lim, coll_hit;
  logic [1:0]        col_sel;
  logic [XW:0]       px_base;
  logic [XW:0]       px   [8];
  logic [BUF_IW-1:0] pidx [8];
  logic [PIXW-1:0]   npix [8];
  logic [PIXW-1:0]   opix [8];
  logic [7:0]        in_scr;

  assign scr_w    = wide_q ? SCR_W : SCR_N;
  assign list_end = (idx_q == cnt_q);
  assign at_lim   = (idx_q == (wide_q ? LSPR_W : LSPR_N)) ||
                    (tiles_q == (wide_q ? LTIL_W : LTIL_N));

  assign spr_idx    = idx_q;
  assign draw_valid = busy && !list_end && !at_lim;
  assign col_sel    = spr_hflip ? (spr_size - col_q) : col_q;
  assign draw_tile  = spr_tile + TILEW'(col_sel);
  assign px_base    = {1'b0, spr_x} + {{(XW-4){1'b0}}, col_q, 3'b000};
  assign draw_x     = px_base[XW-1:0];

  assign rd_pix = ({1'b0, rd_x} < SCR_W) ? buf_q[rd_x[BUF_IW-1:0]] : '0;

  always_comb begin
    coll_hit = 1'b0;
    for (int i = 0; i < 8; i++) begin
      px[i]     = px_base + (XW+1)'(i);
      pidx[i]   = px[i][BUF_IW-1:0];
      in_scr[i] = px[i] < scr_w;
      opix[i]   = in_scr[i] ? buf_q[pidx[i]] : '0;
      npix[i]   = spr_hflip ? pat_pix[PIXW*i +: PIXW] : pat_pix[PIXW*(7-i) +: PIXW];
      if (in_scr[i] && opix[i] != '0 && npix[i] != '0) coll_hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < BUF_PIX; j++) buf_q[j] <= '0;
    end else if (line_start) begin
      for (int j = 0; j < BUF_PIX; j++) buf_q[j] <= '0;
    end else if (draw_valid) begin
      for (int i = 0; i < 8; i++)
        if (in_scr[i] && opix[i] == '0) buf_q[pidx[i]] <= npix[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wide_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      col_q   <= '0;
      tiles_q <= '0;
    end else if (line_start) begin
      busy    <= 1'b1;
      wide_q  <= wide;
      cnt_q   <= spr_count;
      idx_q   <= '0;
      col_q   <= '0;
      tiles_q <= '0;
    end else if (draw_valid) begin
      tiles_q <= tiles_q + CNTW'(1);
      if (col_q == spr_size) begin
        col_q <= '0;
        idx_q <= idx_q + IDXW'(1);
      end else begin
        col_q <= col_q + 2'd1;
      end
    end else begin
      busy <= 1'b0;
    end
  end

  wire ov_set   = busy && !line_start && !list_end && at_lim;
  wire coll_set = draw_valid && !line_start && coll_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow  <= 1'b0;
      collision <= 1'b0;
    end else begin
      overflow  <= ov_set   | (overflow  & ~status_rd);
      collision <= coll_set | (collision & ~status_rd);
    end
  end
endmodule

// File: rtl/sprite_line_sched_chk.sv
module sprite_line_sched_chk #(
  parameter int XW           = 9,
  parameter int IDXW         = 6,
  parameter int WIDE_CELLS   = 40,
  parameter int NARROW_CELLS = 32,
  parameter int WIDE_SPR     = 20,
  parameter int NARROW_SPR   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            line_start,
  input logic            wide,
  input logic            status_rd,
  input logic            busy,
  input logic            draw_valid,
  input logic [XW-1:0]   draw_x,
  input logic [IDXW-1:0] spr_idx,
  input logic            overflow,
  input logic            collision
);
  localparam logic [7:0]      TW = 8'(WIDE_CELLS);
  localparam logic [7:0]      TN = 8'(NARROW_CELLS);
  localparam logic [IDXW-1:0] SW = IDXW'(WIDE_SPR);
  localparam logic [IDXW-1:0] SN = IDXW'(NARROW_SPR);

  logic [7:0] nd;
  logic       wq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nd <= '0;
      wq <= 1'b0;
    end else if (line_start) begin
      nd <= '0;
      wq <= wide;
    end else if (draw_valid) begin
      nd <= nd + 8'd1;
    end
  end

  assert_draw_in_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    draw_valid |-> busy);
  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(line_start));
  assert_tile_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
    draw_valid |-> nd < (wq ? TW : TN));
  assert_sprite_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    draw_valid |-> spr_idx < (wq ? SW : SN));
  assert_x_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_valid && $past(draw_valid) && !$past(line_start) && spr_idx == $past(spr_idx))
      |-> draw_x == $past(draw_x) + XW'(8));
  assert_flags_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !busy) |=> (!overflow && !collision));
  assert_coll_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && !status_rd) |=> collision);
endmodule

bind sprite_line_sched sprite_line_sched_chk #(
  .XW(XW), .IDXW(IDXW), .WIDE_CELLS(WIDE_CELLS), .NARROW_CELLS(NARROW_CELLS),
  .WIDE_SPR(WIDE_SPR), .NARROW_SPR(NARROW_SPR)
) i_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .wide(wide),
  .status_rd(status_rd), .busy(busy), .draw_valid(draw_valid), .draw_x(draw_x),
  .spr_idx(spr_idx), .overflow(overflow), .collision(collision)
);

// File: tb/test_sprite_line_sched.sv
`timescale 1ns/1ps
module test_sprite_line_sched;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        line_start = 1'b0, wide = 1'b1, status_rd = 1'b0;
  logic [5:0]  spr_count = '0, spr_idx;
  logic [8:0]  spr_x, draw_x, rd_x = '0;
  logic [1:0]  spr_size;
  logic [10:0] spr_tile, draw_tile;
  logic        spr_hflip, draw_valid, busy, overflow, collision;
  logic [31:0] pat_pix;
  logic [3:0]  rd_pix;

  int b_x [64], b_sz [64], b_tile [64], b_flip [64];
  int e_buf [320], e_tile [64], e_x [64];
  int e_nd, e_ov, e_col;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  sprite_line_sched i_sprite_line_sched (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .wide(wide),
    .spr_count(spr_count), .spr_idx(spr_idx), .spr_x(spr_x), .spr_size(spr_size),
    .spr_tile(spr_tile), .spr_hflip(spr_hflip), .draw_valid(draw_valid),
    .draw_tile(draw_tile), .draw_x(draw_x), .pat_pix(pat_pix), .rd_x(rd_x),
    .rd_pix(rd_pix), .status_rd(status_rd), .busy(busy), .overflow(overflow),
    .collision(collision));

  function automatic logic [31:0] pat_of(logic [10:0] t);
    logic [31:0] r = '0;
    if (t[10]) return 32'h0;
    if (t[9]) return 32'hF000_0000;
    for (int i = 0; i < 8; i++) r[4*(7-i) +: 4] = 4'(((int'(t[3:0]) + i) % 15) + 1);
    return r;
  endfunction

  always_comb begin
    spr_x     = 9'(b_x[spr_idx]);
    spr_size  = 2'(b_sz[spr_idx]);
    spr_tile  = 11'(b_tile[spr_idx]);
    spr_hflip = b_flip[spr_idx] != 0;
  end
  assign pat_pix = pat_of(draw_tile);

  task automatic check(bit ok, string tag, string what, int got, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic clear_list();
    for (int k = 0; k < 64; k++) begin b_x[k] = 0; b_sz[k] = 0; b_tile[k] = 0; b_flip[k] = 0; end
  endtask

  task automatic model(int n, bit w);
    int scr = w ? 320 : 256, sl = w ? 20 : 16, tl = w ? 40 : 32;
    bit stop = 0;
    logic [31:0] p;
    for (int k = 0; k < 320; k++) e_buf[k] = 0;
    e_nd = 0; e_ov = 0; e_col = 0;
    for (int s = 0; s < n && !stop; s++) begin
      if (s == sl) begin e_ov = 1; stop = 1; end
      for (int c = 0; c <= b_sz[s] && !stop; c++) begin
        if (e_nd == tl) begin e_ov = 1; stop = 1; end
        else begin
          e_tile[e_nd] = b_tile[s] + (b_flip[s] != 0 ? b_sz[s] - c : c);
          e_x[e_nd] = b_x[s] + 8 * c;
          p = pat_of(11'(e_tile[e_nd]));
          for (int i = 0; i < 8; i++) begin
            int pos = e_x[e_nd] + i;
            int nv = b_flip[s] != 0 ? int'(p[4*i +: 4]) : int'(p[4*(7-i) +: 4]);
            if (pos < scr) begin
              if (e_buf[pos] != 0 && nv != 0) e_col = 1;
              if (e_buf[pos] == 0) e_buf[pos] = nv;
            end
          end
          e_nd++;
        end
      end
    end
  endtask

  task automatic status_pulse();
    @(negedge clk) status_rd = 1'b1;
    @(negedge clk) status_rd = 1'b0;
  endtask

  task automatic run_line(int n, bit w, string tag);
    int nd = 0, bad = 0, guard = 0, bb = 0;
    model(n, w);
    status_pulse();
    line_start = 1'b1; wide = w; spr_count = 6'(n);
    @(negedge clk) line_start = 1'b0;
    check(busy == 1'b1, "R11", {tag, " busy after start"}, busy, 1);
    while (busy && guard < 1000) begin
      if (draw_valid) begin
        if (nd < 64 && (int'(draw_tile) != e_tile[nd] || int'(draw_x) != e_x[nd])) bad++;
        nd++;
      end
      guard++;
      @(negedge clk);
    end
    check(nd == e_nd, tag, "draw count", nd, e_nd);
    check(bad == 0, tag, "draw tile/x mismatches", bad, 0);
    for (int x = 0; x < 320; x++) begin
      rd_x = 9'(x);
      #0.1;
      if (int'(rd_pix) != e_buf[x]) bb++;
    end
    check(bb == 0, tag, "buffer pixel mismatches", bb, 0);
    check(int'(overflow) == e_ov, tag, "overflow", overflow, e_ov);
    check(int'(collision) == e_col, tag, "collision", collision, e_col);
  endtask

  task automatic t_reset();
    int nz = 0;
    check(!busy && !overflow && !collision, "R1", "status after reset", {busy, overflow, collision}, 0);
    for (int x = 0; x < 320; x += 7) begin rd_x = 9'(x); #0.1; if (rd_pix != 0) nz++; end
    check(nz == 0, "R1", "buffer after reset", nz, 0);
  endtask

  task automatic t_basic();
    clear_list();
    b_x[0] = 0;   b_sz[0] = 0; b_tile[0] = 5;
    b_x[1] = 40;  b_sz[1] = 3; b_tile[1] = 16;
    b_x[2] = 100; b_sz[2] = 1; b_tile[2] = 300;
    run_line(3, 1, "R3 basic order");
  endtask

  task automatic t_flip_clip();
    clear_list();
    b_x[0] = 40;  b_sz[0] = 2; b_tile[0] = 20; b_flip[0] = 1;
    b_x[1] = 316; b_sz[1] = 1; b_tile[1] = 7;
    run_line(2, 1, "R4 flip+wide clip");
    clear_list();
    b_x[0] = 250; b_sz[0] = 1; b_tile[0] = 3; b_flip[0] = 1;
    run_line(1, 0, "R4 narrow clip");
  endtask

  task automatic t_overlap();
    clear_list();
    b_x[0] = 10; b_sz[0] = 0; b_tile[0] = 1;
    b_x[1] = 14; b_sz[1] = 0; b_tile[1] = 8;
    run_line(2, 1, "R5 R6 opaque overlap");
    rd_x = 9'd14; #0.1;
    check(rd_pix == 4'(((1 + 4) % 15) + 1), "R5", "earlier pixel kept", rd_pix, ((1 + 4) % 15) + 1);
  endtask

  task automatic t_transparent();
    clear_list();
    b_x[0] = 100; b_sz[0] = 0; b_tile[0] = 512;
    b_x[1] = 101; b_sz[1] = 0; b_tile[1] = 2;
    b_x[2] = 200; b_sz[2] = 0; b_tile[2] = 1024;
    b_x[3] = 200; b_sz[3] = 0; b_tile[3] = 4;
    run_line(4, 1, "R6 transparent overlap");
  endtask

  task automatic t_sprite_limit();
    clear_list();
    for (int k = 0; k < 22; k++) begin b_x[k] = 14 * k; b_tile[k] = k; end
    run_line(22, 1, "R7 wide sprite limit");
    run_line(18, 0, "R7 narrow sprite limit");
    run_line(20, 1, "R9 exact sprite fill");
  endtask

  task automatic t_tile_budget();
    clear_list();
    for (int k = 0; k < 11; k++) begin b_x[k] = 0; b_sz[k] = 3; b_tile[k] = 1024; end
    run_line(11, 1, "R8 wide budget");
    run_line(10, 1, "R9 exact budget fill");
    b_sz[9] = 2;
    run_line(11, 1, "R8 mid-sprite cut");
    run_line(9, 0, "R8 narrow budget");
  endtask

  task automatic t_clear_line();
    run_line(0, 1, "R2 clear on new line");
    check(busy == 1'b0, "R11", "idle after empty line", busy, 0);
  endtask

  task automatic t_status();
    clear_list();
    for (int k = 0; k < 22; k++) begin b_x[k] = 4; b_tile[k] = k; end
    run_line(22, 1, "R10 set both flags");
    status_pulse();
    check(!overflow && !collision, "R10", "flags after status read", {overflow, collision}, 0);
  endtask

  initial begin
    #(4ns * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    clear_list();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_flip_clip();
    t_overlap();
    t_transparent();
    t_sprite_limit();
    t_tile_budget();
    t_clear_line();
    t_status();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule